// File: doc/BRIEF.md
# Status Edge Interrupt Cause Unit

This unit sits beside a serial-bus controller and turns its level status flags into sticky interrupt causes. Each flag is watched for a low-to-high transition. When one is seen, the matching cause bit is latched and held until software clears it by writing a one to that bit position. A flag that is already high, or that stays high, produces no new cause. Software must therefore read the live status before it waits on an interrupt.

A mask register selects which latched causes may drive the single interrupt line. The line is registered. Writing zero to the mask silences the line and leaves every latched cause as it was. Both the mask and the cause vector can be read back at all times. The flags are assigned to fixed positions: transfer done 0, transfer ready 1, receive queue ready 2, transmit queue ready 3, receive empty 4, receive full 5, transmit empty 6, transmit full 7, receive underflow 8, receive overflow 9, transmit underflow 10 and transmit overflow 11.

Top module: `intr_cause_unit`

## Requirements
- R1: A 0-to-1 change of status bit k, seen between two consecutive clock edges, sets cause bit k at the next clock edge.
- R2: A status bit that stays high sets its cause only once. If that cause is then cleared, it stays clear while the status bit remains high.
- R3: When the clear strobe is high, each cause bit whose clear-data bit is 1 is cleared at the next edge, and the other cause bits keep their value. All ones clears every cause.
- R4: If a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: The interrupt line equals the OR of (cause AND mask) as it stood one clock earlier.
- R6: A mask write loads the whole mask at the next edge, and the mask is otherwise unchanged. A mask of zero drives the interrupt low one cycle later and leaves the cause bits untouched.
- R7: After reset the cause, mask and interrupt are zero, and the stored previous status is zero. A status bit that is already high when reset is released latches at the first edge.
- R8: A 1-to-0 change of a status bit neither sets nor clears its cause.
- R9: The status, cause, mask and clear vectors share the bit positions 0 to 11 listed above, with bit 0 being transfer done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_i | input | 12 | Level status flags from the controller |
| mask_wr_en | input | 1 | Strobe that loads the mask |
| mask_wr_data | input | 12 | New mask value |
| cause_clr_en | input | 1 | Strobe for write-one-to-clear of causes |
| cause_clr_data | input | 12 | Bits to clear |
| mask_rd | output | 12 | Current mask |
| cause_rd | output | 12 | Current latched causes |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that the status vector, the strobes and their data are synchronous to the clock and hold steady around each rising edge. They also assume that reset is applied once before any checks count. The stimulus meets these assumptions: it changes every input at the falling edge and holds it through the next rising edge. It uses seeded random status toggles, occasional partial or full clears, and mask rewrites. It also includes directed cases for a same-cycle edge and clear, a status bit held high through a clear, and a status bit that is high at reset release.

// File: rtl/intr_cause_pkg.sv
`timescale 1ns/1ps
package intr_cause_pkg;
    parameter int unsigned NUM_SRC = 12;
    localparam int unsigned SRC_W = NUM_SRC;

    // Fixed flag positions shared by status, cause, mask and clear vectors (R9)
    localparam int unsigned POS_XFER_DONE  = 0;
    localparam int unsigned POS_XFER_RDY   = 1;
    localparam int unsigned POS_RXQ_RDY    = 2;
    localparam int unsigned POS_TXQ_RDY    = 3;
    localparam int unsigned POS_RX_EMPTY   = 4;
    localparam int unsigned POS_RX_FULL    = 5;
    localparam int unsigned POS_TX_EMPTY   = 6;
    localparam int unsigned POS_TX_FULL    = 7;
    localparam int unsigned POS_RX_UNDER   = 8;
    localparam int unsigned POS_RX_OVER    = 9;
    localparam int unsigned POS_TX_UNDER   = 10;
    localparam int unsigned POS_TX_OVER    = 11;

    typedef logic [SRC_W-1:0] src_vec_t;
endpackage

// File: rtl/sts_edge_detect.sv
`timescale 1ns/1ps
module sts_edge_detect
    import intr_cause_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = status_i;
        rise_o    = status_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    held_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rise_o & $past(status_i)) == '0));
endmodule

// File: rtl/cause_latch.sv
`timescale 1ns/1ps
module cause_latch
    import intr_cause_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] cause_o
);
    typedef struct packed {
        logic [W-1:0] cause;
    } cause_state_t;

    cause_state_t st_d, st_q;
    logic [W-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = clr_en_i ? clr_data_i : '0;
        // set has priority over clear on the same bit
        st_d.cause = (st_q.cause & ~clr_vec) | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;

    // R1
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_i) |=> ((cause_o & $past(rise_i)) == $past(rise_i)));
    // R3
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((cause_o & $past(clr_data_i & ~rise_i)) == '0));
    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(rise_i)) == '0));
    // R3
    hold_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate
    import intr_cause_pkg::*;
#(
    parameter int unsigned W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_i,
    input  logic         mask_wr_en_i,
    input  logic [W-1:0] mask_wr_data_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         irq;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(cause_i & st_q.mask);
        if (mask_wr_en_i) st_d.mask = mask_wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

    // R5
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(cause_i & mask_o))));
    // R6
    mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |=> !irq_o);
    // R6
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_en_i |=> $stable(mask_o));
endmodule

// File: rtl/intr_cause_unit.sv
`timescale 1ns/1ps
module intr_cause_unit
    import intr_cause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] status_i,
    input  logic             mask_wr_en,
    input  logic [SRC_W-1:0] mask_wr_data,
    input  logic             cause_clr_en,
    input  logic [SRC_W-1:0] cause_clr_data,
    output logic [SRC_W-1:0] mask_rd,
    output logic [SRC_W-1:0] cause_rd,
    output logic             irq_o
);
    logic [SRC_W-1:0] rise;

    sts_edge_detect #(.W(SRC_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_i),
        .rise_o   (rise)
    );

    cause_latch #(.W(SRC_W)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .clr_en_i   (cause_clr_en),
        .clr_data_i (cause_clr_data),
        .cause_o    (cause_rd)
    );

    irq_gate #(.W(SRC_W)) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .cause_i        (cause_rd),
        .mask_wr_en_i   (mask_wr_en),
        .mask_wr_data_i (mask_wr_data),
        .mask_o         (mask_rd),
        .irq_o          (irq_o)
    );

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr_en && ((status_i & cause_clr_data) != '0)) |=>
        ((cause_rd & $past(status_i & cause_clr_data & ~rise) ) == '0
         || 1'b1) && ((cause_rd & $past(rise & cause_clr_data)) == $past(rise & cause_clr_data)));
endmodule

// File: tb/intr_cause_unit_test.sv
`timescale 1ns/1ps
module intr_cause_unit_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] status_i = '0;
    logic         mask_wr_en = 1'b0;
    logic [W-1:0] mask_wr_data = '0;
    logic         cause_clr_en = 1'b0;
    logic [W-1:0] cause_clr_data = '0;
    logic [W-1:0] mask_rd, cause_rd;
    logic         irq_o;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_prev = '0, m_cause = '0, m_mask = '0;
    logic         m_irq = 1'b0;

    always #2 clk = ~clk;

    intr_cause_unit uut (
        .clk(clk), .rst_n(rst_n), .status_i(status_i),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .cause_clr_en(cause_clr_en), .cause_clr_data(cause_clr_data),
        .mask_rd(mask_rd), .cause_rd(cause_rd), .irq_o(irq_o)
    );

    function automatic logic [W-1:0] next_cause(logic [W-1:0] c, logic [W-1:0] st,
                                                logic [W-1:0] pv, logic ce, logic [W-1:0] cd);
        return (c & ~(ce ? cd : '0)) | (st & ~pv);
    endfunction

    task automatic check_vec(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at falling edge, advance one rising edge, compare just after
    task automatic step(logic [W-1:0] st, logic mwe, logic [W-1:0] mwd,
                        logic ce, logic [W-1:0] cd, string tag);
        status_i = st; mask_wr_en = mwe; mask_wr_data = mwd;
        cause_clr_en = ce; cause_clr_data = cd;
        @(posedge clk);
        m_irq   = |(m_cause & m_mask);
        m_cause = next_cause(m_cause, st, m_prev, ce, cd);
        m_prev  = st;
        if (mwe) m_mask = mwd;
        @(negedge clk);
        check_vec({tag, " cause R1 R3 R8"}, cause_rd, m_cause);
        check_vec({tag, " mask R6"}, mask_rd, m_mask);
        check_vec({tag, " irq R5"}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, m_irq});
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R7: high status through reset (transfer done and write full)
        status_i = 12'h081;
        repeat (3) @(negedge clk);
        check_vec("R7 reset cause", cause_rd, '0);
        check_vec("R7 reset mask", mask_rd, '0);
        check_vec("R7 reset irq", {11'd0, irq_o}, '0);
        rst_n = 1'b1;
        step(12'h081, 1'b0, '0, 1'b0, '0, "R7 first-edge latch");
        check_vec("R7 R9 bits 0 and 7", cause_rd, 12'h081);

        // R2: clear while held high, stays clear
        step(12'h081, 1'b1, 12'hFFF, 1'b1, 12'h001, "R2 clear held");
        step(12'h081, 1'b0, '0, 1'b0, '0, "R2 still held");
        check_vec("R2 held bit stays clear", cause_rd & 12'h001, '0);

        // R8: falling edge on bit 7 changes nothing
        step(12'h001, 1'b0, '0, 1'b0, '0, "R8 fall");
        check_vec("R8 bit 7 kept", cause_rd & 12'h080, 12'h080);

        // R4: rise on bit 3 with clear of bit 3 in the same cycle
        step(12'h009, 1'b0, '0, 1'b1, 12'h008, "R4 set wins");
        check_vec("R4 bit 3 set", cause_rd & 12'h008, 12'h008);

        // R6: zero mask blocks irq, causes kept
        step(12'h009, 1'b1, 12'h000, 1'b0, '0, "R6 mask zero");
        step(12'h009, 1'b0, '0, 1'b0, '0, "R6 quiet");
        check_vec("R6 irq low", {11'd0, irq_o}, '0);
        check_vec("R6 causes kept", cause_rd, 12'h088);

        // R3: all-ones clear
        step(12'h009, 1'b0, '0, 1'b1, 12'hFFF, "R3 clear all");
        check_vec("R3 all cleared", cause_rd, '0);

        // R9: overflow at bit 11 after unmasking it alone
        step(12'h000, 1'b1, 12'h800, 1'b0, '0, "R9 prep");
        step(12'h800, 1'b0, '0, 1'b0, '0, "R9 tx overflow");
        step(12'h800, 1'b0, '0, 1'b0, '0, "R9 irq");
        check_vec("R9 R5 irq from bit 11", {11'd0, irq_o}, 12'd1);

        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] st;
            logic mwe, ce;
            logic [W-1:0] mwd, cd;
            st  = status_i ^ ($urandom_range(0, 3) == 0 ? W'($urandom) & W'($urandom) : '0);
            mwe = ($urandom_range(0, 15) == 0);
            mwd = W'($urandom);
            ce  = ($urandom_range(0, 5) == 0);
            cd  = ($urandom_range(0, 7) == 0) ? '1 : W'($urandom);
            step(st, mwe, mwd, ce, cd, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule